// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic section of a small accumulator-based processor. It keeps an 8-bit accumulator, a temporary operand register, a temporary-accumulator holding stage and a five-bit flag register. A combinational core combines the temporary accumulator, the temporary operand and the stored carry. It performs addition and subtraction with or without carry, compare, three bitwise operations and four rotates.

An instruction decoder drives the block each cycle. It supplies the operation code, the load enables and source selects for every storage element, a flag-load enable and the bus-drive selects. All clocked storage shares one system clock. A phase strobe marks the cycle in which the clocked registers may load; the strobe stands in for the second phase of a two-phase clock. The temporary accumulator behaves as a transparent stage: while its enable is high it passes its selected source straight to the core, and when the enable drops it keeps the last value. The core result can be written back into the accumulator or driven onto the internal bus through a data-plus-enable driver.

Top module: `acc_alu_unit`

## Requirements
- R1: After reset the accumulator, the temporary register, the held temporary-accumulator value and all flags are zero, and `bus_oe` is low.
- R2: Operation codes 0 ADD, 1 ADC, 2 SUB and 3 SBB produce the 8-bit sum or difference of ACT and TMP. ADC adds the stored carry and SBB subtracts it. ADD and SUB ignore the stored carry.
- R3: Operation codes 4 AND, 5 XOR and 6 OR produce the bitwise result of ACT and TMP, and they clear both the carry and the auxiliary-carry flags.
- R4: Operation codes 8 to 11 rotate ACT. Code 8 rotates left with bit 7 copied to bit 0. Code 9 rotates right with bit 0 copied to bit 7. Code 10 rotates left through the carry. Code 11 rotates right through the carry. Each rotate loads carry with the bit shifted out and leaves the other four flags unchanged.
- R5: `flags` has sign at bit 4, zero at bit 3, auxiliary carry at bit 2, parity at bit 1 and carry at bit 0. For codes 0 to 7, sign is result bit 7, zero is set for a zero result, and parity is set when the result has an even number of ones.
- R6: Carry is the carry out of bit 7 for addition and the borrow for subtraction and compare. Auxiliary carry is the carry out of bit 3 for addition, or the borrow into bit 4 for subtraction and compare.
- R7: Operation code 7 CMP updates the flags as a subtraction would, but it never writes the accumulator, even when the accumulator is loading from the core.
- R8: The accumulator, TMP and the flags change only on a clock edge where `ph2_stb` is high and their own enable is high. The accumulator loads from the bus when `acc_src` is 0 and from the core result when it is 1. TMP loads from the bus when `tmp_src` is 0 and from the accumulator when it is 1.
- R9: While `act_en` is high, ACT follows its source in the same cycle: the bus when `act_src` is 0, the accumulator when it is 1. While `act_en` is low, ACT keeps the last value it passed.
- R10: `bus_oe` is high when `drv_alu` or `drv_acc` is high. `drv_alu` has priority and drives the core result; `drv_acc` alone drives the accumulator. With `bus_oe` low, `bus_out` is all zeros.
- R11: Operation codes 12 to 15 pass ACT through as the result and leave every flag unchanged, even when flags are being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph2_stb | input | 1 | Load phase strobe for clocked registers |
| bus_in | input | 8 | Internal bus value seen by the block |
| op_sel | input | 4 | Operation code |
| act_en | input | 1 | Temporary accumulator transparent enable |
| act_src | input | 1 | ACT source: 0 bus, 1 accumulator |
| tmp_ld | input | 1 | TMP load enable |
| tmp_src | input | 1 | TMP source: 0 bus, 1 accumulator |
| acc_ld | input | 1 | Accumulator load enable |
| acc_src | input | 1 | Accumulator source: 0 bus, 1 core result |
| flag_ld | input | 1 | Flag register load enable |
| drv_alu | input | 1 | Drive core result onto the bus |
| drv_acc | input | 1 | Drive accumulator onto the bus |
| alu_res | output | 8 | Combinational core result |
| bus_out | output | 8 | Bus drive data, zero when released |
| bus_oe | output | 1 | Bus drive enable |
| flags | output | 5 | Sign, zero, aux carry, parity, carry (bits 4 to 0) |

## Verification
Two functions meet on the same strobe edge: the accumulator writes back the core result while the flag register captures that result's status. In the same cycle, ACT passes a fresh bus value through its transparent stage. Each operation is issued as one strobed cycle that sets ACT, loads the accumulator from the core and loads the flags together. On the following cycle the accumulator is placed on the bus, and both the written value and the flags are compared against an independent model. Carry-chained sequences (ADD then ADC, SUB then SBB) show whether the carry from one edge feeds the next operation correctly. A compare issued with accumulator write-back enabled shows that the flags move while the accumulator stays put.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_RAL  = 4'd10,
    OP_RAR  = 4'd11
  } alu_op_e;

  // bit 4 sign, 3 zero, 2 aux carry, 1 parity, 0 carry
  typedef struct packed {
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  typedef struct packed {
    logic upd_szp;
    logic upd_aux;
    logic upd_cry;
  } flag_mask_t;

endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] act_v,
  input  logic [W-1:0] tmp_v,
  input  logic         cy_in,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] res,
  output flags_t       flg_new,
  output flag_mask_t   flg_mask
);

  localparam int unsigned NIB = 4;

  alu_op_e        op;
  logic           cin_eff;
  logic [W:0]     sum_w;
  logic [W:0]     dif_w;
  logic [NIB:0]   sum_n;
  logic [NIB:0]   dif_n;
  logic           cry_v;
  logic           aux_v;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    cin_eff = ((op == OP_ADC) || (op == OP_SBB)) ? cy_in : 1'b0;
    sum_w = {1'b0, act_v} + {1'b0, tmp_v} + {{W{1'b0}}, cin_eff};
    dif_w = {1'b0, act_v} - {1'b0, tmp_v} - {{W{1'b0}}, cin_eff};
    sum_n = {1'b0, act_v[NIB-1:0]} + {1'b0, tmp_v[NIB-1:0]} + {{NIB{1'b0}}, cin_eff};
    dif_n = {1'b0, act_v[NIB-1:0]} - {1'b0, tmp_v[NIB-1:0]} - {{NIB{1'b0}}, cin_eff};
  end

  always_comb begin
    res      = act_v;
    cry_v    = 1'b0;
    aux_v    = 1'b0;
    flg_mask = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        res      = sum_w[W-1:0];
        cry_v    = sum_w[W];
        aux_v    = sum_n[NIB];
        flg_mask = '{upd_szp: 1'b1, upd_aux: 1'b1, upd_cry: 1'b1};
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        res      = dif_w[W-1:0];
        cry_v    = dif_w[W];
        aux_v    = dif_n[NIB];
        flg_mask = '{upd_szp: 1'b1, upd_aux: 1'b1, upd_cry: 1'b1};
      end
      OP_AND: begin
        res      = act_v & tmp_v;
        flg_mask = '{upd_szp: 1'b1, upd_aux: 1'b1, upd_cry: 1'b1};
      end
      OP_XOR: begin
        res      = act_v ^ tmp_v;
        flg_mask = '{upd_szp: 1'b1, upd_aux: 1'b1, upd_cry: 1'b1};
      end
      OP_OR: begin
        res      = act_v | tmp_v;
        flg_mask = '{upd_szp: 1'b1, upd_aux: 1'b1, upd_cry: 1'b1};
      end
      OP_RLC: begin
        res      = {act_v[W-2:0], act_v[W-1]};
        cry_v    = act_v[W-1];
        flg_mask = '{upd_szp: 1'b0, upd_aux: 1'b0, upd_cry: 1'b1};
      end
      OP_RRC: begin
        res      = {act_v[0], act_v[W-1:1]};
        cry_v    = act_v[0];
        flg_mask = '{upd_szp: 1'b0, upd_aux: 1'b0, upd_cry: 1'b1};
      end
      OP_RAL: begin
        res      = {act_v[W-2:0], cy_in};
        cry_v    = act_v[W-1];
        flg_mask = '{upd_szp: 1'b0, upd_aux: 1'b0, upd_cry: 1'b1};
      end
      OP_RAR: begin
        res      = {cy_in, act_v[W-1:1]};
        cry_v    = act_v[0];
        flg_mask = '{upd_szp: 1'b0, upd_aux: 1'b0, upd_cry: 1'b1};
      end
      default: begin
        res      = act_v;
        flg_mask = '0;
      end
    endcase
  end

  always_comb begin
    flg_new.sgn = res[W-1];
    flg_new.zro = ~|res;
    flg_new.aux = aux_v;
    flg_new.par = ~^res;
    flg_new.cry = cry_v;
  end

endmodule

// File: rtl/acc_alu_regs.sv
module acc_alu_regs
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ph2_stb,
  input  logic [W-1:0] bus_in,
  input  logic         act_en,
  input  logic         act_src,
  input  logic         tmp_ld,
  input  logic         tmp_src,
  input  logic         acc_ld,
  input  logic         acc_src,
  input  logic         acc_blk,
  input  logic [W-1:0] alu_res,
  input  logic         flag_ld,
  input  flags_t       flg_new,
  input  flag_mask_t   flg_mask,
  output logic [W-1:0] act_q,
  output logic [W-1:0] tmp_q,
  output logic [W-1:0] acc_q,
  output flags_t       flags_q
);

  logic [W-1:0] act_mux;
  logic [W-1:0] act_hold, act_hold_nxt;
  logic [W-1:0] tmp_nxt;
  logic [W-1:0] acc_nxt;
  flags_t       flags_nxt;
  logic         acc_we;
  logic         tmp_we;
  logic         flg_we;

  // transparent stage emulated with a holding register
  always_comb begin
    act_mux      = act_src ? acc_q : bus_in;
    act_q        = act_en ? act_mux : act_hold;
    act_hold_nxt = act_q;
  end

  always_comb begin
    acc_we    = ph2_stb & acc_ld & ~(acc_src & acc_blk);
    tmp_we    = ph2_stb & tmp_ld;
    flg_we    = ph2_stb & flag_ld;
    acc_nxt   = acc_we ? (acc_src ? alu_res : bus_in) : acc_q;
    tmp_nxt   = tmp_we ? (tmp_src ? acc_q : bus_in) : tmp_q;
    flags_nxt = flags_q;
    if (flg_we) begin
      if (flg_mask.upd_szp) begin
        flags_nxt.sgn = flg_new.sgn;
        flags_nxt.zro = flg_new.zro;
        flags_nxt.par = flg_new.par;
      end
      if (flg_mask.upd_aux) flags_nxt.aux = flg_new.aux;
      if (flg_mask.upd_cry) flags_nxt.cry = flg_new.cry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hold <= '0;
      tmp_q    <= '0;
      acc_q    <= '0;
      flags_q  <= '0;
    end else begin
      act_hold <= act_hold_nxt;
      tmp_q    <= tmp_nxt;
      acc_q    <= acc_nxt;
      flags_q  <= flags_nxt;
    end
  end

endmodule

// File: rtl/acc_alu_busdrv.sv
module acc_alu_busdrv #(
  parameter int unsigned W = 8
) (
  input  logic         drv_alu,
  input  logic         drv_acc,
  input  logic [W-1:0] alu_res,
  input  logic [W-1:0] acc_q,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);

  always_comb begin
    bus_oe  = drv_alu | drv_acc;
    bus_out = '0;
    if (drv_alu)      bus_out = alu_res;
    else if (drv_acc) bus_out = acc_q;
  end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ph2_stb,
  input  logic [W-1:0] bus_in,
  input  logic [3:0]   op_sel,
  input  logic         act_en,
  input  logic         act_src,
  input  logic         tmp_ld,
  input  logic         tmp_src,
  input  logic         acc_ld,
  input  logic         acc_src,
  input  logic         flag_ld,
  input  logic         drv_alu,
  input  logic         drv_acc,
  output logic [W-1:0] alu_res,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic [4:0]   flags
);

  logic         rst_s1, rst_sync_n;
  logic [W-1:0] act_q, tmp_q, acc_q;
  flags_t       flags_q, flg_new;
  flag_mask_t   flg_mask;
  logic         acc_blk;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  assign acc_blk = (op_sel == OP_CMP);

  acc_alu_core #(.W(W)) u_core (
    .act_v    (act_q),
    .tmp_v    (tmp_q),
    .cy_in    (flags_q.cry),
    .op_sel   (op_sel),
    .res      (alu_res),
    .flg_new  (flg_new),
    .flg_mask (flg_mask)
  );

  acc_alu_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ph2_stb  (ph2_stb),
    .bus_in   (bus_in),
    .act_en   (act_en),
    .act_src  (act_src),
    .tmp_ld   (tmp_ld),
    .tmp_src  (tmp_src),
    .acc_ld   (acc_ld),
    .acc_src  (acc_src),
    .acc_blk  (acc_blk),
    .alu_res  (alu_res),
    .flag_ld  (flag_ld),
    .flg_new  (flg_new),
    .flg_mask (flg_mask),
    .act_q    (act_q),
    .tmp_q    (tmp_q),
    .acc_q    (acc_q),
    .flags_q  (flags_q)
  );

  acc_alu_busdrv #(.W(W)) u_bus (
    .drv_alu (drv_alu),
    .drv_acc (drv_acc),
    .alu_res (alu_res),
    .acc_q   (acc_q),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );

  assign flags = flags_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ph2_stb,
  input logic [3:0]   op_sel,
  input logic         acc_ld,
  input logic         acc_src,
  input logic         flag_ld,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic [4:0]   flags
);

  a_r8_acc_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ph2_stb |=> $stable(acc_q));

  a_r8_flags_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph2_stb && flag_ld) |=> $stable(flags));

  a_r10_bus_released_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0));

  a_r7_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_stb && acc_ld && acc_src && op_sel == 4'd7) |=> $stable(acc_q));

  a_r4_rotate_only_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_stb && flag_ld && op_sel >= 4'd8 && op_sel <= 4'd11) |=> $stable(flags[4:1]));

  a_r3_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_stb && flag_ld && op_sel >= 4'd4 && op_sel <= 4'd6) |=> (flags[0] == 1'b0 && flags[2] == 1'b0));

  a_r11_pass_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_stb && flag_ld && op_sel >= 4'd12) |=> $stable(flags));

endmodule

bind acc_alu_unit acc_alu_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ph2_stb (ph2_stb),
  .op_sel  (op_sel),
  .acc_ld  (acc_ld),
  .acc_src (acc_src),
  .flag_ld (flag_ld),
  .acc_q   (acc_q),
  .bus_out (bus_out),
  .bus_oe  (bus_oe),
  .flags   (flags)
);

// File: tb/acc_alu_unit_bench.sv
`timescale 1ns/1ps
module acc_alu_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ph2_stb, act_en, act_src, tmp_ld, tmp_src;
  logic       acc_ld, acc_src, flag_ld, drv_alu, drv_acc;
  logic [7:0] bus_in;
  logic [3:0] op_sel;
  logic [7:0] alu_res, bus_out;
  logic       bus_oe;
  logic [4:0] flags;

  always #2 clk = ~clk;

  acc_alu_unit u_acc_alu_unit (
    .clk(clk), .rst_n(rst_n), .ph2_stb(ph2_stb), .bus_in(bus_in),
    .op_sel(op_sel), .act_en(act_en), .act_src(act_src), .tmp_ld(tmp_ld),
    .tmp_src(tmp_src), .acc_ld(acc_ld), .acc_src(acc_src), .flag_ld(flag_ld),
    .drv_alu(drv_alu), .drv_acc(drv_acc), .alu_res(alu_res),
    .bus_out(bus_out), .bus_oe(bus_oe), .flags(flags)
  );

  typedef struct {
    string      req;
    logic [7:0] acc;
    logic [4:0] flg;
  } exp_t;

  exp_t       sb_q[$];
  int         n_checks = 0;
  int         n_fails  = 0;
  bit         mon_go   = 1'b0;
  bit         done     = 1'b0;
  logic [7:0] m_acc;
  logic [4:0] m_flg;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    ph2_stb = 0; act_en = 0; act_src = 0; tmp_ld = 0; tmp_src = 0;
    acc_ld = 0; acc_src = 0; flag_ld = 0; drv_alu = 0; drv_acc = 0;
    bus_in = 8'h00; op_sel = 4'd12;
  endtask

  // independent reference of one operation
  task automatic ref_calc(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op,
                          output logic [7:0] r, output logic [4:0] nf);
    int t, n, c;
    nf = m_flg;
    c  = ((op == 4'd1) || (op == 4'd3)) ? int'(m_flg[0]) : 0;
    r  = a;
    case (op)
      4'd0, 4'd1: begin
        t = int'(a) + int'(b) + c; n = int'(a % 16) + int'(b % 16) + c;
        r = t[7:0]; nf[0] = (t > 255); nf[2] = (n > 15);
      end
      4'd2, 4'd3, 4'd7: begin
        t = int'(a) - int'(b) - c; n = int'(a % 16) - int'(b % 16) - c;
        r = t[7:0]; nf[0] = (t < 0); nf[2] = (n < 0);
      end
      4'd4: begin r = a & b; nf[0] = 0; nf[2] = 0; end
      4'd5: begin r = a ^ b; nf[0] = 0; nf[2] = 0; end
      4'd6: begin r = a | b; nf[0] = 0; nf[2] = 0; end
      4'd8:  begin r = {a[6:0], a[7]};     nf[0] = a[7]; end
      4'd9:  begin r = {a[0], a[7:1]};     nf[0] = a[0]; end
      4'd10: begin r = {a[6:0], m_flg[0]}; nf[0] = a[7]; end
      4'd11: begin r = {m_flg[0], a[7:1]}; nf[0] = a[0]; end
      default: r = a;
    endcase
    if (op <= 4'd7) begin
      nf[4] = r[7];
      nf[3] = (r == 8'h00);
      nf[1] = ($countones(r) % 2 == 0);
    end
  endtask

  // driver: TMP load cycle, then one strobed op cycle, then acc onto bus
  task automatic do_op(input string req, input logic [7:0] a, input logic [7:0] b, input logic [3:0] op);
    logic [7:0] r;
    logic [4:0] nf;
    exp_t e;
    @(negedge clk); idle();
    bus_in = b; tmp_ld = 1; ph2_stb = 1;
    @(negedge clk); idle();
    bus_in = a; act_en = 1; op_sel = op; acc_ld = 1; acc_src = 1; flag_ld = 1; ph2_stb = 1;
    ref_calc(a, b, op, r, nf);
    #1 check({req, " result"}, {24'h0, alu_res}, {24'h0, r});
    e.req = req; e.acc = (op == 4'd7) ? m_acc : r; e.flg = nf;
    sb_q.push_back(e);
    m_acc = e.acc; m_flg = nf;
    @(negedge clk); idle();
    drv_acc = 1; op_sel = 4'd12; mon_go = 1'b1;
    wait (mon_go == 1'b0);
  endtask

  // monitor: pops expectations and compares what the block produced
  initial begin
    forever begin
      @(negedge clk); #1;
      if (mon_go) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.req, " acc"},   {24'h0, bus_out}, {24'h0, e.acc});
        check({e.req, " flags"}, {27'h0, flags},   {27'h0, e.flg});
        mon_go = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle();
    m_acc = 8'h00; m_flg = 5'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    check("R1 flags", {27'h0, flags}, 32'h0);
    check("R1 bus_oe", {31'h0, bus_oe}, 32'h0);
    check("R1 act", {24'h0, alu_res}, 32'h0);
    @(negedge clk); drv_acc = 1; #1;
    check("R1 acc", {24'h0, bus_out}, 32'h0);

    // R2/R5/R6 arithmetic, carry chains
    do_op("R2 R6 ADD aux", 8'h3A, 8'h26, 4'd0);
    do_op("R2 R5 ADD wrap zero", 8'hFF, 8'h01, 4'd0);
    do_op("R2 ADC carry in", 8'h10, 8'h20, 4'd1);
    do_op("R2 R6 SUB borrow", 8'h10, 8'h20, 4'd2);
    do_op("R2 SBB borrow in", 8'h05, 8'h03, 4'd3);
    do_op("R2 ADD ignores carry", 8'h01, 8'h01, 4'd0);
    do_op("R5 ADD sign odd", 8'h70, 8'h11, 4'd0);
    // R7 compare
    do_op("R7 CMP equal", 8'h40, 8'h40, 4'd7);
    do_op("R7 CMP less", 8'h12, 8'h34, 4'd7);
    // R3 logic after a carry-setting op
    do_op("R3 AND", 8'hF0, 8'h3C, 4'd4);
    do_op("R2 SUB set carry", 8'h00, 8'h01, 4'd2);
    do_op("R3 XOR clears carry", 8'hA5, 8'hA5, 4'd5);
    do_op("R3 OR", 8'h81, 8'h02, 4'd6);
    // R4 rotates
    do_op("R4 RLC", 8'h81, 8'h00, 4'd8);
    do_op("R4 RRC", 8'h01, 8'h00, 4'd9);
    do_op("R4 RAL", 8'h40, 8'h00, 4'd10);
    do_op("R4 RAR", 8'h02, 8'h00, 4'd11);
    // R11 pass codes keep flags
    do_op("R11 pass 12", 8'h5C, 8'h00, 4'd12);
    do_op("R11 pass 15", 8'hC3, 8'hFF, 4'd15);

    // R8 load needs strobe
    @(negedge clk); idle();
    bus_in = 8'h99; acc_ld = 1; flag_ld = 1; op_sel = 4'd0;
    @(negedge clk); idle(); drv_acc = 1; #1;
    check("R8 acc no strobe", {24'h0, bus_out}, {24'h0, m_acc});
    check("R8 flags no strobe", {27'h0, flags}, {27'h0, m_flg});
    @(negedge clk); idle();
    bus_in = 8'h99; acc_ld = 1; ph2_stb = 1;
    @(negedge clk); idle(); drv_acc = 1; #1;
    check("R8 acc from bus", {24'h0, bus_out}, 32'h99);
    // R8 TMP from accumulator; ACT from bus 0 so SUB gives 0 - 0x99
    @(negedge clk); idle(); tmp_src = 1; tmp_ld = 1; ph2_stb = 1;
    @(negedge clk); idle(); act_en = 1; bus_in = 8'h00; op_sel = 4'd2; #1;
    check("R8 tmp from acc", {24'h0, alu_res}, 32'h67);

    // R9 transparent then hold
    @(negedge clk); idle(); act_en = 1; bus_in = 8'h3E; #1;
    check("R9 follows bus", {24'h0, alu_res}, 32'h3E);
    bus_in = 8'h11; #1;
    check("R9 follows change", {24'h0, alu_res}, 32'h11);
    @(negedge clk); idle(); bus_in = 8'hEE; #1;
    check("R9 holds", {24'h0, alu_res}, 32'h11);
    @(negedge clk); idle(); act_en = 1; act_src = 1; #1;
    check("R9 from acc", {24'h0, alu_res}, 32'h99);

    // R10 bus driver
    @(negedge clk); idle(); act_en = 1; bus_in = 8'h5A; drv_alu = 1; drv_acc = 1; #1;
    check("R10 alu priority", {24'h0, bus_out}, 32'h5A);
    check("R10 oe", {31'h0, bus_oe}, 32'h1);
    @(negedge clk); idle(); #1;
    check("R10 released oe", {31'h0, bus_oe}, 32'h0);
    check("R10 released data", {24'h0, bus_out}, 32'h0);

    @(negedge clk); idle();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule